// File: doc/BRIEF.md
# Random Step Value Latch

This block supplies a step sequencer with random step numbers. An 8-stage serial shift register takes one new random bit on every cycle of a fast shift enable. That enable runs freely and has no relation to the sequencer's step clock. The bits come from an internal 16-bit maximal-length LFSR that advances on the same enable. For test, an external serial bit can replace the LFSR bit.

The block samples the sequencer's main step clock level in the system clock domain and detects its high-to-low transitions. Each transition gives a one-cycle capture strobe. The strobe freezes the current shift register contents into an 8-bit holding register, and that register keeps its value until the next strobe. The low four bits of the held value drive the load inputs of the step counter. In random mode the counter jumps to a new random step on each step clock.

Top module: `rnd_step_latch`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the shift register, the holding register and the step clock level copy to zero, and seeds the LFSR with 16'hACE1. After reset, held_o and step_load_o read zero.
- R2: On a clock edge with shift_en_i high, the shift register moves one place toward bit 7. The new random bit enters bit 0 and the old bit 7 is dropped.
- R3: On a clock edge with shift_en_i low, neither the shift register nor the LFSR changes.
- R4: When ser_ovr_i is high, the new bit is ser_bit_i. Otherwise it is LFSR bit 15. The LFSR advances on every shift whatever ser_ovr_i is: it moves toward bit 15 and takes into bit 0 the XOR of bits 15, 14, 12 and 3.
- R5: A capture happens at a clock edge where step_clk_i is low and was high at the previous edge. held_o then takes the shift register contents from before that edge, so a shift at the same edge is not included.
- R6: At any other edge, held_o keeps its value. This covers a rising step clock, a steady level, and any amount of shifting.
- R7: step_load_o always equals bits 3:0 of held_o.
- R8: A step clock that stays low gives exactly one capture, however long it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en_i | input | 1 | Free-running shift enable for the shift register and LFSR |
| step_clk_i | input | 1 | Main step clock level, already in the clk domain |
| ser_ovr_i | input | 1 | Selects ser_bit_i instead of the LFSR as the random bit |
| ser_bit_i | input | 1 | External serial random bit |
| held_o | output | 8 | Held random value |
| step_load_o | output | 4 | Low four held bits, for the step counter load inputs |

## Verification
A shift and a capture can fall on the same clock edge. This happens whenever the step clock falls while the shift enable is high. The bench provokes this case directly with a known serial pattern. It also provokes it many times during a long sweep that walks through all combinations of shift enable, step clock, override and serial bit. The bench keeps its own arithmetic model of the LFSR, the shift register and the edge detector. A coincident capture is judged correct only if the held value equals the model's contents from before the shift.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
    localparam int unsigned RSL_SR_W    = 8;
    localparam int unsigned RSL_LFSR_W  = 16;
    localparam int unsigned RSL_LOAD_W  = 4;
    localparam logic [15:0] RSL_TAPS    = 16'hD008;
    localparam logic [15:0] RSL_SEED    = 16'hACE1;

    typedef enum logic {
        SRC_LFSR = 1'b0,
        SRC_EXT  = 1'b1
    } bit_src_e;
endpackage

// File: rtl/rsl_lfsr.sv
module rsl_lfsr #(
    parameter int unsigned W    = 16,
    parameter logic [W-1:0] TAPS = 16'hD008,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic         bit_o,
    output logic [W-1:0] state_o
);
    typedef struct packed {
        logic [W-1:0] poly;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;
    logic     fb;

    always_comb begin
        st_d = st_q;
        fb   = ^(st_q.poly & TAPS);
        if (adv_i) begin
            st_d.poly = {st_q.poly[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.poly <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o   = st_q.poly[W-1];
    assign state_o = st_q.poly;
endmodule

// File: rtl/rsl_shifter.sv
module rsl_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] sr_o
);
    typedef struct packed {
        logic [W-1:0] chain;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) begin
            st_d.chain = {st_q.chain[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o = st_q.chain;
endmodule

// File: rtl/rsl_fall_detect.sv
module rsl_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o
);
    typedef struct packed {
        logic lvl;
    } fd_st_t;

    fd_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
        fall_o   = st_q.lvl & ~lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rnd_step_latch.sv
module rnd_step_latch #(
    parameter int unsigned SR_W   = rsl_pkg::RSL_SR_W,
    parameter int unsigned LFSR_W = rsl_pkg::RSL_LFSR_W,
    parameter int unsigned LOAD_W = rsl_pkg::RSL_LOAD_W,
    parameter logic [LFSR_W-1:0] TAPS = rsl_pkg::RSL_TAPS,
    parameter logic [LFSR_W-1:0] SEED = rsl_pkg::RSL_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic              step_clk_i,
    input  logic              ser_ovr_i,
    input  logic              ser_bit_i,
    output logic [SR_W-1:0]   held_o,
    output logic [LOAD_W-1:0] step_load_o
);
    import rsl_pkg::*;

    typedef struct packed {
        logic [SR_W-1:0] val;
    } hold_st_t;

    hold_st_t          hold_d, hold_q;
    bit_src_e          src_sel;
    logic              lfsr_bit;
    logic              new_bit;
    logic              strobe;
    logic [SR_W-1:0]   sr_w;
    logic [LFSR_W-1:0] lfsr_w;

    rsl_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (shift_en_i),
        .bit_o   (lfsr_bit),
        .state_o (lfsr_w)
    );

    assign src_sel = ser_ovr_i ? SRC_EXT : SRC_LFSR;

    always_comb begin
        case (src_sel)
            SRC_EXT: new_bit = ser_bit_i;
            default: new_bit = lfsr_bit;
        endcase
    end

    rsl_shifter #(.W(SR_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_en_i),
        .bit_i   (new_bit),
        .sr_o    (sr_w)
    );

    rsl_fall_detect u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (step_clk_i),
        .fall_o (strobe)
    );

    always_comb begin
        hold_d = hold_q;
        if (strobe) begin
            hold_d.val = sr_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.val <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign held_o      = hold_q.val;
    assign step_load_o = hold_q.val[LOAD_W-1:0];
endmodule

// File: rtl/rnd_step_latch_chk.sv
module rnd_step_latch_chk #(
    parameter int unsigned SR_W   = 8,
    parameter int unsigned LFSR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_en_i,
    input logic              step_clk_i,
    input logic              ser_ovr_i,
    input logic              ser_bit_i,
    input logic [SR_W-1:0]   held_o,
    input logic [SR_W-1:0]   sr_i,
    input logic [LFSR_W-1:0] lfsr_i
);
    logic seen_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_hi_q <= 1'b0;
        end else begin
            seen_hi_q <= step_clk_i;
        end
    end

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> sr_i[SR_W-1:1] == $past(sr_i[SR_W-2:0]));

    // R3
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |=> ($stable(sr_i) && $stable(lfsr_i)));

    // R4
    ext_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en_i && ser_ovr_i) |=> sr_i[0] == $past(ser_bit_i));

    // R4
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_i != '0);

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_hi_q && !step_clk_i) |=> held_o == $past(sr_i));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seen_hi_q && !step_clk_i) |=> $stable(held_o));
endmodule

bind rnd_step_latch rnd_step_latch_chk #(.SR_W(SR_W), .LFSR_W(LFSR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (shift_en_i),
    .step_clk_i (step_clk_i),
    .ser_ovr_i  (ser_ovr_i),
    .ser_bit_i  (ser_bit_i),
    .held_o     (held_o),
    .sr_i       (sr_w),
    .lfsr_i     (lfsr_w)
);

// File: tb/rnd_step_latch_tb.sv
module rnd_step_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_en = 1'b0;
    logic       step_clk = 1'b0;
    logic       ser_ovr = 1'b0;
    logic       ser_bit = 1'b0;
    logic [7:0] held;
    logic [3:0] load;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    logic [15:0] m_lfsr;
    logic [7:0]  m_sr;
    logic [7:0]  m_held;
    logic        m_lvl;

    always #4 clk = ~clk;

    rnd_step_latch dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en_i  (shift_en),
        .step_clk_i  (step_clk),
        .ser_ovr_i   (ser_ovr),
        .ser_bit_i   (ser_bit),
        .held_o      (held),
        .step_load_o (load)
    );

    task automatic check(input string tag);
        n_vec++;
        if (held !== m_held) begin
            n_miss++;
            $display("FAIL %s held actual %h expected %h", tag, held, m_held);
        end
        n_vec++;
        if (load !== m_held[3:0]) begin
            n_miss++;
            $display("FAIL R7 (%s) load actual %h expected %h", tag, load, m_held[3:0]);
        end
    endtask

    task automatic cyc(input logic sh, input logic sc, input logic ov,
                       input logic sb, input string tag);
        logic b;
        shift_en = sh; step_clk = sc; ser_ovr = ov; ser_bit = sb;
        @(posedge clk);
        if (m_lvl && !sc) m_held = m_sr;
        if (sh) begin
            b      = ov ? sb : m_lfsr[15];
            m_sr   = {m_sr[6:0], b};
            m_lfsr = {m_lfsr[14:0], ^(m_lfsr & 16'hD008)};
        end
        m_lvl = sc;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        logic [7:0] pat;
        m_lfsr = 16'hACE1; m_sr = '0; m_held = '0; m_lvl = 1'b0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        // R1: a capture without shifting returns the cleared shift register
        cyc(0, 1, 0, 0, "R1");
        cyc(0, 0, 0, 0, "R1");
        // R4: sixteen LFSR-fed shifts from the seed, then capture
        for (int i = 0; i < 16; i++) cyc(1, 1, 0, 0, "R4");
        cyc(0, 0, 0, 0, "R4");
        // R2: a known pattern through the override path
        pat = 8'b1011_0011;
        for (int i = 7; i >= 0; i--) cyc(1, 0, 1, pat[i], "R2");
        cyc(0, 1, 0, 0, "R2");
        cyc(0, 0, 0, 0, "R2");
        if (held !== 8'hB3) begin
            n_miss++; $display("FAIL R2 pattern actual %h expected b3", held);
        end
        n_vec++;
        // R3: no shifting, step clock toggles, same capture repeated
        for (int i = 0; i < 6; i++) cyc(0, i[0], 1, 1, "R3");
        // R6: rising step clock with shifting leaves held alone
        cyc(1, 1, 1, 1, "R6");
        cyc(1, 1, 1, 0, "R6");
        // R5: fall coincident with a shift captures pre-shift contents
        cyc(1, 0, 1, 1, "R5");
        // R8: staying low gives no further capture
        for (int i = 0; i < 10; i++) cyc(1, 0, 1, i[1], "R8");
        // sweep over all input combinations, several rounds
        for (int i = 0; i < 6000; i++) begin
            logic [3:0] v;
            v = 4'(i ^ (i >> 3) ^ (i * 5));
            cyc(v[0] | v[3], v[1], v[2] & i[4], v[3] ^ i[6],
                (m_lvl && !v[1]) ? "R5" : "R6");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule